// File: doc/BRIEF.md
# Scanline Interrupt Counter Driven by Video Address Edges

This block turns the video fetch pattern into a CPU interrupt that fires after a programmed number of scanlines. The video side fetches pattern data from two halves of its address space. Each time a strobed video address moves from the low half to the high half, bit 12 of that address rises, and this block treats the rise as one scanline tick. An 8-bit down counter counts those ticks. When the count runs out and interrupts are enabled, a level interrupt line to the CPU goes high. It stays high until software disables it.

Real fetch streams toggle bit 12 several times within a short burst. After every detected rise, a lockout timer therefore ignores further rises for a fixed number of CPU cycles. A rise that arrives during the lockout still restarts the timer. When the counter is at zero, the next accepted rise loads it from a software-written reload value instead of wrapping. Software has four write strobes sharing one data bus: store the reload value, force a reload, disable (this also clears the interrupt), and enable.

Top module: `vedge_irq_counter`

## Requirements
- R1: After reset the interrupt is low, the counter, reload value, enable flag and lockout timer are zero, and the remembered bit 12 is 0. The first strobed address with bit 12 set is therefore a rise.
- R2: A rise is a strobed address (`vaddr_valid`=1) with bit 12 = 1 when the previous strobed address had bit 12 = 0. Addresses presented without a strobe are not observed. Repeated strobes with bit 12 high give only one rise.
- R3: Every rise restarts a lockout of 6 cycles, whether it was acted on or not. A rise acts on the counter only if it comes at least 7 cycles after the previous rise.
- R4: An accepted rise that finds the counter at zero loads the reload value and never raises the interrupt. With a reload value of 0 the interrupt never fires.
- R5: An accepted rise that finds the counter nonzero decrements it. If the result is zero and interrupts are enabled, `irq` is high on the clock edge that samples that rise. With reload value N, that is the (N+1)-th accepted rise after a forced reload.
- R6: `wr_latch` stores `wr_data` as the reload value. `wr_reload` clears the counter to zero, and it wins over a rise sampled in the same cycle.
- R7: `wr_disable` clears the enable flag and drives `irq` low on the next edge. It wins over an interrupt being raised in the same cycle.
- R8: `wr_enable` sets the enable flag but never raises `irq` by itself. Once high, `irq` stays high through further rises and enable writes until a disable write.
- R9: While interrupts are disabled the counter still runs. It reaches zero without an interrupt, and the next accepted rise reloads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vaddr_valid | input | 1 | Video address strobe, at most one per cycle |
| vaddr | input | 13 | Video address; bit 12 is watched |
| wr_latch | input | 1 | Store reload value from wr_data |
| wr_reload | input | 1 | Clear counter so next accepted rise reloads |
| wr_disable | input | 1 | Clear enable flag and interrupt |
| wr_enable | input | 1 | Set enable flag |
| wr_data | input | 8 | CPU write data |
| irq | output | 1 | Level interrupt request to the CPU |

## Verification
The assertions check the following on every cycle:
- the interrupt holds until a disable write;
- a disable write drops both the interrupt and the enable flag;
- the interrupt rises only on an accepted rise that takes an enabled counter from one to zero;
- every rise re-arms the lockout, which otherwise counts down;
- a forced reload leaves the counter at zero.

Only the bench scenarios can show the end-to-end behaviour: the exact rise on which the interrupt appears for each reload value, the 7-cycle acceptance boundary, that unstrobed and repeated-high addresses are ignored, and how the register writes interact with rises.

// File: rtl/vedge_irq_pkg.sv
package vedge_irq_pkg;
   typedef struct packed {
      logic latch;
      logic reload;
      logic dis;
      logic ena;
   } cpu_wr_t;

   function automatic int dly_width(input int lockout);
      return (lockout < 1) ? 1 : $clog2(lockout + 1);
   endfunction
endpackage

// File: rtl/vedge_detect.sv
module vedge_detect #(
   parameter int ADDR_W   = 13,
   parameter int EDGE_BIT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [ADDR_W-1:0] addr,
   output logic              rise
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      prev_q <= 1'b0;
      else if (strobe) prev_q <= addr[EDGE_BIT];
   end

   assign rise = strobe & addr[EDGE_BIT] & ~prev_q;
endmodule

// File: rtl/vedge_lockout.sv
module vedge_lockout #(
   parameter int LOCKOUT = 6,
   localparam int DLY_W  = vedge_irq_pkg::dly_width(LOCKOUT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic             accept,
   output logic [DLY_W-1:0] dly
);
   generate
      if (LOCKOUT == 0) begin : g_nofilter
         assign accept = rise;
         assign dly    = '0;
      end else begin : g_filter
         localparam logic [DLY_W-1:0] ARM = DLY_W'(LOCKOUT);
         logic [DLY_W-1:0] dly_q;
         always_ff @(posedge clk) begin
            if (!rst_n)           dly_q <= '0;
            else if (rise)        dly_q <= ARM;
            else if (dly_q != '0) dly_q <= dly_q - 1'b1;
         end
         assign accept = rise & (dly_q == '0);
         assign dly    = dly_q;
      end
   endgenerate
endmodule

// File: rtl/vedge_count.sv
module vedge_count
   import vedge_irq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  cpu_wr_t          wr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt,
   output logic             en,
   output logic             irq
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] latch_q, cnt_q;
   logic             en_q, irq_q, hit;

   assign hit = accept & ~wr.reload & (cnt_q == ONE) & en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         cnt_q   <= '0;
         en_q    <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (wr.latch) latch_q <= wr_data;
         if (wr.reload)                  cnt_q <= '0;
         else if (accept && cnt_q == '0) cnt_q <= latch_q;
         else if (accept)                cnt_q <= cnt_q - 1'b1;
         if (wr.dis)      en_q <= 1'b0;
         else if (wr.ena) en_q <= 1'b1;
         if (wr.dis)   irq_q <= 1'b0;
         else if (hit) irq_q <= 1'b1;
      end
   end

   assign cnt = cnt_q;
   assign en  = en_q;
   assign irq = irq_q;
endmodule

// File: rtl/vedge_irq_counter.sv
module vedge_irq_counter
   import vedge_irq_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int EDGE_BIT = 12,
   parameter int CNT_W    = 8,
   parameter int LOCKOUT  = 6,
   localparam int DLY_W   = dly_width(LOCKOUT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vaddr_valid,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              wr_latch,
   input  logic              wr_reload,
   input  logic              wr_disable,
   input  logic              wr_enable,
   input  logic [CNT_W-1:0]  wr_data,
   output logic              irq
);
   generate
      if (EDGE_BIT >= ADDR_W || EDGE_BIT < 0) begin : g_bad_bit
         $error("EDGE_BIT must lie inside the address bus");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (LOCKOUT < 0) begin : g_bad_lock
         $error("LOCKOUT must not be negative");
      end
   endgenerate

   cpu_wr_t          wr_w;
   logic             rise_w, accept_w, en_w;
   logic [DLY_W-1:0] dly_w;
   logic [CNT_W-1:0] cnt_w;

   assign wr_w = '{latch: wr_latch, reload: wr_reload, dis: wr_disable, ena: wr_enable};

   vedge_detect #(.ADDR_W(ADDR_W), .EDGE_BIT(EDGE_BIT)) u_detect (
      .clk(clk), .rst_n(rst_n), .strobe(vaddr_valid), .addr(vaddr), .rise(rise_w)
   );

   vedge_lockout #(.LOCKOUT(LOCKOUT)) u_lockout (
      .clk(clk), .rst_n(rst_n), .rise(rise_w), .accept(accept_w), .dly(dly_w)
   );

   vedge_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .accept(accept_w), .wr(wr_w), .wr_data(wr_data),
      .cnt(cnt_w), .en(en_w), .irq(irq)
   );
endmodule

// File: rtl/vedge_irq_checker.sv
module vedge_irq_checker #(
   parameter int CNT_W   = 8,
   parameter int LOCKOUT = 6,
   parameter int DLY_W   = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_reload,
   input logic             wr_disable,
   input logic             irq,
   input logic             rise,
   input logic             accept,
   input logic [DLY_W-1:0] dly,
   input logic [CNT_W-1:0] cnt,
   input logic             en
);
   p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !wr_disable |=> irq);

   p_disable_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_disable |=> !irq && !en);

   p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(accept && en && cnt == CNT_W'(1) && !wr_reload));

   p_lockout_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> (LOCKOUT == 0) || (int'(dly) == LOCKOUT));

   p_lockout_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dly != '0) && !rise |=> dly == $past(dly) - 1'b1);

   p_reload_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reload |=> cnt == '0);

   p_zero_load_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept && cnt == '0 && !irq |=> !irq);
endmodule

bind vedge_irq_counter vedge_irq_checker #(
   .CNT_W(CNT_W), .LOCKOUT(LOCKOUT), .DLY_W(DLY_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_reload(wr_reload), .wr_disable(wr_disable),
   .irq(irq), .rise(rise_w), .accept(accept_w), .dly(dly_w), .cnt(cnt_w), .en(en_w)
);

// File: tb/vedge_irq_counter_bench.sv
module vedge_irq_counter_bench;
   localparam logic [12:0] LO = 13'h0123;
   localparam logic [12:0] HI = 13'h1040;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vaddr_valid = 1'b0;
   logic [12:0] vaddr = '0;
   logic        wr_latch = 1'b0, wr_reload = 1'b0, wr_disable = 1'b0, wr_enable = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        irq;
   int          n_chk = 0;
   int          n_fail = 0;

   always #10 clk = ~clk;

   vedge_irq_counter u_vedge_irq_counter (
      .clk(clk), .rst_n(rst_n), .vaddr_valid(vaddr_valid), .vaddr(vaddr),
      .wr_latch(wr_latch), .wr_reload(wr_reload), .wr_disable(wr_disable),
      .wr_enable(wr_enable), .wr_data(wr_data), .irq(irq)
   );

   task automatic check(input logic got, input logic exp, input string req);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: irq got %0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, return at the following negedge
   task automatic tick(input logic v, input logic [12:0] a, input logic [3:0] w,
                       input logic [7:0] d);
      vaddr_valid = v; vaddr = a;
      {wr_latch, wr_reload, wr_disable, wr_enable} = w;
      wr_data = d;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, LO, 4'b0000, 8'h00);
   endtask

   // low strobe, high strobe (the rise), then idle: next rise is g cycles later
   task automatic line_chk(input int g, input logic pre, input logic exp, input string req);
      tick(1'b1, LO, 4'b0000, 8'h00);
      check(irq, pre, req);
      tick(1'b1, HI, 4'b0000, 8'h00);
      check(irq, exp, req);
      idle(g - 2);
   endtask

   task automatic setup(input int n, input logic ena);
      tick(1'b0, LO, 4'b0010, 8'h00);
      tick(1'b0, LO, 4'b0100, 8'h00);
      tick(1'b0, LO, 4'b1000, 8'(n));
      if (ena) tick(1'b0, LO, 4'b0001, 8'h00);
      idle(8);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(irq, 1'b0, "R1 irq low in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(irq, 1'b0, "R1 irq low after reset");
      // R1: remembered bit is 0, counter is 0 -> first high strobe is a loading rise
      tick(1'b0, LO, 4'b1000, 8'd1);
      tick(1'b0, LO, 4'b0001, 8'h00);
      check(irq, 1'b0, "R1 enable alone");
      tick(1'b1, HI, 4'b0000, 8'h00);
      check(irq, 1'b0, "R1 first rise loads");
      idle(6);
      line_chk(8, 1'b0, 1'b1, "R1 second rise fires");

      // R5 sweep: reload value N fires on rise N+1 exactly
      for (int n = 1; n <= 12; n++) begin
         setup(n, 1'b1);
         for (int k = 1; k <= n + 1; k++)
            line_chk(8, 1'b0, (k == n + 1), "R5 count sweep");
         line_chk(8, 1'b1, 1'b1, "R8 irq holds over reload rise");
         tick(1'b0, LO, 4'b0001, 8'h00);
         check(irq, 1'b1, "R8 enable write keeps irq");
         tick(1'b0, LO, 4'b0010, 8'h00);
         check(irq, 1'b0, "R7 disable drops irq");
      end

      // R3 sweep: second rise g cycles after first is accepted only when g >= 7
      for (int g = 2; g <= 10; g++) begin
         setup(1, 1'b1);
         line_chk(g, 1'b0, 1'b0, "R3 first rise loads");
         line_chk(8, 1'b0, (g >= 7), "R3 lockout boundary");
      end

      // R3: rejected rises restart the lockout
      setup(1, 1'b1);
      line_chk(4, 1'b0, 1'b0, "R3 load");
      line_chk(4, 1'b0, 1'b0, "R3 rejected at 4");
      line_chk(8, 1'b0, 1'b0, "R3 rejected, restarted by previous");
      line_chk(8, 1'b0, 1'b1, "R3 accepted after quiet gap");

      // R4: reload value 0 never fires
      setup(0, 1'b1);
      for (int k = 0; k < 4; k++) line_chk(8, 1'b0, 1'b0, "R4 zero reload");

      // R6: forced reload mid-count
      setup(3, 1'b1);
      line_chk(8, 1'b0, 1'b0, "R6 load 3");
      line_chk(8, 1'b0, 1'b0, "R6 dec to 2");
      tick(1'b0, LO, 4'b0100, 8'h00);
      idle(1);
      line_chk(8, 1'b0, 1'b0, "R6 reload loads 3");
      line_chk(8, 1'b0, 1'b0, "R6 dec 2");
      line_chk(8, 1'b0, 1'b0, "R6 dec 1");
      line_chk(8, 1'b0, 1'b1, "R6 fires after forced reload");

      // R6: forced reload wins over a same-cycle rise
      setup(1, 1'b1);
      line_chk(8, 1'b0, 1'b0, "R6 load 1");
      tick(1'b1, LO, 4'b0000, 8'h00);
      tick(1'b1, HI, 4'b0100, 8'h00);
      check(irq, 1'b0, "R6 reload beats rise");
      idle(6);
      line_chk(8, 1'b0, 1'b0, "R6 reload after clash");
      line_chk(8, 1'b0, 1'b1, "R6 fires after clash");

      // R7: disable wins over a same-cycle interrupt
      setup(1, 1'b1);
      line_chk(8, 1'b0, 1'b0, "R7 load 1");
      tick(1'b1, LO, 4'b0000, 8'h00);
      tick(1'b1, HI, 4'b0010, 8'h00);
      check(irq, 1'b0, "R7 disable beats irq");
      idle(6);
      line_chk(8, 1'b0, 1'b0, "R7 disabled reload");
      line_chk(8, 1'b0, 1'b0, "R7 disabled zero");

      // R9: count while disabled, then enable
      setup(2, 1'b0);
      line_chk(8, 1'b0, 1'b0, "R9 load 2");
      line_chk(8, 1'b0, 1'b0, "R9 dec 1");
      line_chk(8, 1'b0, 1'b0, "R9 zero without irq");
      tick(1'b0, LO, 4'b0001, 8'h00);
      check(irq, 1'b0, "R8 enable alone no irq");
      idle(1);
      line_chk(8, 1'b0, 1'b0, "R9 reload after zero");
      line_chk(8, 1'b0, 1'b0, "R9 dec 1 enabled");
      line_chk(8, 1'b0, 1'b1, "R9 fires enabled");

      // R2: repeated high strobes and unstrobed addresses are not rises
      setup(1, 1'b1);
      line_chk(8, 1'b0, 1'b0, "R2 load 1");
      for (int k = 0; k < 3; k++) begin
         tick(1'b1, HI, 4'b0000, 8'h00);
         check(irq, 1'b0, "R2 high repeat");
         idle(7);
      end
      tick(1'b1, LO, 4'b0000, 8'h00);
      idle(8);
      for (int k = 0; k < 3; k++) begin
         tick(1'b0, HI, 4'b0000, 8'h00);
         tick(1'b0, LO, 4'b0000, 8'h00);
         idle(6);
      end
      tick(1'b1, LO, 4'b0000, 8'h00);
      check(irq, 1'b0, "R2 unstrobed ignored");
      idle(8);
      line_chk(8, 1'b0, 1'b1, "R2 real rise fires");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule